// File: doc/BRIEF.md
# Interrupt Vector Remap Translator

This block sits on the processor's instruction and data address path and redirects any access that falls in the vector window (byte addresses 0 to 191) to a selectable region. The target is chosen by a small configuration register. A select bit picks flash or SRAM. A 5-bit segment number moves the window in 1024-byte steps inside the chosen memory. Every address outside the window passes through untouched. Translation is combinational, so it adds no cycle to a fetch.

The configuration register is written and read through a simple register port. Software writes a word at register offset 0. The new mapping governs translation from the clock cycle after the write edge. Segment numbers above 7 are only legal with flash. If SRAM is selected with such a segment, the block does not remap at all. It also raises a configuration-error flag that stays set until reset.

A three-state controller tracks the effective mode:
- `ST_DIRECT` means translation is the identity (flash, segment 0).
- `ST_REMAP` means the window is redirected.
- `ST_CLAMPED` means an illegal SRAM segment was written.

Every accepted write moves the controller, from any state, to the state that the written value selects:
- SRAM with a segment of 8 or more leads to `ST_CLAMPED`.
- SRAM, or a non-zero segment, otherwise leads to `ST_REMAP`.
- Flash with segment 0 leads to `ST_DIRECT`.

Reset returns the controller to `ST_DIRECT`.

Top module: `vec_remap_xlat`

## Requirements
- R1: After reset the readback is 0, the error flag is 0, and every address is output unchanged.
- R2: Any input address of 192 or more is output unchanged, whatever the configuration.
- R3: With bit 0 = 0 (flash) and segment k in bits 5:1, an input address a < 192 is output as k*1024 + a; segment 0 gives the identity.
- R4: With bit 0 = 1 (SRAM) and segment k from 0 to 7, an input address a < 192 is output as 0x1000_0000 + k*1024 + a.
- R5: Segments 8 to 31 are honoured when flash is selected.
- R6: Writing bit 0 = 1 with a segment of 8 or more disables remapping (identity output) and sets the error flag. The flag stays set through later valid writes until reset.
- R7: Readback bits 5:0 return the last accepted write's bits 5:0, and bits 31:6 read as zero.
- R8: A write is accepted only when the write strobe is high and the register address equals 0. Other register addresses, including unaligned ones, change nothing.
- R9: A write takes effect from the cycle after its clock edge. In the write cycle itself, translation still follows the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register readback |
| cfg_err | output | 1 | Sticky illegal-configuration flag |
| addr_in | input | 32 | Incoming bus address |
| addr_out | output | 32 | Translated bus address |

## Verification
Two functions can act in the same cycle: a register write, and translation of a window address. The bench provokes this by writing a new mapping while presenting a vector-window address in that same cycle. It then presents the address again in the next cycle. The behavioural model expects the old mapping in the write cycle and the new mapping afterwards. Outputs are compared against the model on every clock, both in directed sequences and in a long stretch of random writes and addresses.

// File: rtl/vremap_pkg.sv
package vremap_pkg;
    typedef enum logic [1:0] {
        ST_DIRECT  = 2'd0,
        ST_REMAP   = 2'd1,
        ST_CLAMPED = 2'd2
    } remap_state_e;

    typedef struct packed {
        logic [4:0] seg;
        logic       sram_sel;
    } remap_cfg_t;
endpackage

// File: rtl/vremap_cfg_fsm.sv
module vremap_cfg_fsm
    import vremap_pkg::*;
#(
    parameter int OFS_W        = 5,
    parameter int SRAM_SEG_MAX = 7,
    parameter int RADDR_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [RADDR_W-1:0] waddr,
    input  logic [OFS_W:0]     wbits,
    output remap_cfg_t         cfg_q,
    output remap_state_e       state_q,
    output logic               err_q
);
    logic         hit;
    remap_cfg_t   wcfg;
    remap_state_e state_d;
    logic         bad_wr;

    assign hit    = wr && (waddr == '0);
    assign wcfg   = remap_cfg_t'(wbits);
    assign bad_wr = wcfg.sram_sel && (int'(wcfg.seg) > SRAM_SEG_MAX);

    always_comb begin
        state_d = state_q;
        if (hit) begin
            if (bad_wr)
                state_d = ST_CLAMPED;
            else if (wcfg.sram_sel || (wcfg.seg != '0))
                state_d = ST_REMAP;
            else
                state_d = ST_DIRECT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DIRECT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            err_q <= 1'b0;
        end else if (hit) begin
            cfg_q <= wcfg;
            if (bad_wr) err_q <= 1'b1;
        end
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_bad_write_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bad_wr) |=> (err_q && state_q == ST_CLAMPED));
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfg_q == $past(wcfg)));
    assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cfg_q));
endmodule

// File: rtl/vremap_addr_xlat.sv
module vremap_addr_xlat
    import vremap_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          WIN_BYTES  = 192,
    parameter int          SEG_BYTES  = 1024,
    parameter logic [31:0] FLASH_BASE = 32'h0000_0000,
    parameter logic [31:0] SRAM_BASE  = 32'h1000_0000
) (
    input  logic [ADDR_W-1:0] a_in,
    input  remap_cfg_t        cfg,
    input  logic              remap_en,
    output logic [ADDR_W-1:0] a_out
);
    localparam int SEG_SH = $clog2(SEG_BYTES);

    logic              in_win;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] seg_ofs;

    assign in_win  = a_in < ADDR_W'(WIN_BYTES);
    assign base    = cfg.sram_sel ? ADDR_W'(SRAM_BASE) : ADDR_W'(FLASH_BASE);
    assign seg_ofs = ADDR_W'(cfg.seg) << SEG_SH;

    always_comb begin
        if (remap_en && in_win) a_out = base + seg_ofs + a_in;
        else                    a_out = a_in;
    end

    always_comb begin
        if (!in_win) assert_outside_passes_R2: assert (a_out == a_in);
    end
endmodule

// File: rtl/vec_remap_xlat.sv
module vec_remap_xlat
    import vremap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        cfg_err,
    input  logic [31:0] addr_in,
    output logic [31:0] addr_out
);
    localparam int OFS_W = 5;

    remap_cfg_t   cfg_q;
    remap_state_e state_q;
    logic         unused_wdata;

    assign unused_wdata = ^cfg_wdata[31:OFS_W+1];

    vremap_cfg_fsm #(.OFS_W(OFS_W), .SRAM_SEG_MAX(7), .RADDR_W(8)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .waddr  (cfg_addr),
        .wbits  (cfg_wdata[OFS_W:0]),
        .cfg_q  (cfg_q),
        .state_q(state_q),
        .err_q  (cfg_err)
    );

    vremap_addr_xlat #(.ADDR_W(32)) u_xlat (
        .a_in    (addr_in),
        .cfg     (cfg_q),
        .remap_en(state_q == ST_REMAP),
        .a_out   (addr_out)
    );

    assign cfg_rdata = {{(32-OFS_W-1){1'b0}}, cfg_q};

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:6] == '0);
    assert_clamped_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLAMPED) |-> (addr_out == addr_in));
    assert_sram_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REMAP && cfg_rdata[0] && addr_in < 32'd192)
            |-> (addr_out[31:28] == 4'h1));
endmodule

// File: tb/tb_vec_remap_xlat.sv
`timescale 1ns/1ps
module tb_vec_remap_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic [31:0] addr_in = '0;
    logic [31:0] addr_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int unsigned m_bits = 0;
    bit          m_err  = 0;

    always #2.5 clk = ~clk;

    vec_remap_xlat dut (.*);

    function automatic logic [31:0] exp_out(input logic [31:0] a);
        int unsigned sel = m_bits & 1;
        int unsigned seg = (m_bits >> 1) & 31;
        if (a >= 192) return a;
        if (sel == 1 && seg >= 8) return a;
        return (sel ? 32'h1000_0000 : 32'h0) + seg * 1024 + a;
    endfunction

    task automatic step(input bit wr, input logic [7:0] ra, input logic [31:0] wd,
                        input logic [31:0] a, input string tag);
        @(negedge clk);
        cfg_wr = wr; cfg_addr = ra; cfg_wdata = wd; addr_in = a;
        #1;
        tests++;
        if (addr_out !== exp_out(a) || cfg_rdata !== m_bits || cfg_err !== m_err) begin
            fails++;
            $display("FAIL %s: in=%h out=%h/%h rdata=%h/%h err=%b/%b", tag, a,
                     addr_out, exp_out(a), cfg_rdata, m_bits, cfg_err, m_err);
        end
        @(posedge clk);
        if (wr && ra == 8'd0) begin
            m_bits = wd & 32'h3F;
            if ((m_bits & 1) == 1 && ((m_bits >> 1) & 31) >= 8) m_err = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cfg_wr = 0;
        #1;
        m_bits = 0; m_err = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #5000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        step(0, 0, 0, 32'h0, "R1 reset addr0");
        step(0, 0, 0, 32'h40, "R1 reset addr40");
        // R3 flash segment 0 identity, R2 boundary
        step(1, 0, 32'h0, 32'd4, "R3 write flash seg0");
        step(0, 0, 0, 32'd191, "R3 flash seg0 edge");
        step(0, 0, 0, 32'd192, "R2 first outside");
        // R9 write with window address in same cycle
        step(1, 0, 32'h6, 32'h10, "R9 write cycle old map");
        step(0, 0, 0, 32'h10, "R3 flash seg3");
        step(0, 0, 0, 32'd191, "R3 flash seg3 top");
        step(0, 0, 0, 32'd192, "R2 outside seg3");
        step(0, 0, 0, 32'h2000, "R2 far outside");
        // R5 flash large segment
        step(1, 0, 32'h3E, 32'h8, "R5 write flash seg31");
        step(0, 0, 0, 32'h8, "R5 flash seg31");
        // R4 sram
        step(1, 0, 32'h1, 32'h0, "R4 write sram seg0");
        step(0, 0, 0, 32'h0, "R4 sram seg0");
        step(1, 0, 32'hFFFF_FF0F, 32'd100, "R7 write sram seg7 junk high");
        step(0, 0, 0, 32'd100, "R4 sram seg7");
        step(0, 0, 0, 32'h1000_0000, "R2 sram addr pass");
        // R8 ignored writes
        step(1, 8'd4, 32'h3E, 32'h20, "R8 wrong offset");
        step(1, 8'd1, 32'h3E, 32'h20, "R8 unaligned");
        step(0, 8'd0, 32'h3E, 32'h20, "R8 no strobe");
        step(0, 0, 0, 32'h20, "R8 state kept");
        // R6 illegal sram segment
        step(1, 0, 32'h11, 32'h20, "R6 write sram seg8");
        step(0, 0, 0, 32'h20, "R6 clamped identity");
        step(1, 0, 32'h4, 32'h20, "R6 valid write after error");
        step(0, 0, 0, 32'h20, "R6 flag sticky");
        do_reset();
        step(0, 0, 0, 32'h20, "R1 reset clears flag");
        // random stretch
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ra = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
            logic [31:0] a = ($urandom % 2) ? ($urandom % 200) : $urandom;
            step(($urandom % 3) == 0, ra, $urandom, a, "R3 R4 R6 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule